// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block turns one command request into the ordered series of byte writes that load an ATA device's task-file registers and start the command. A request carries an opcode, a 48-bit block address, a 16-bit sector count, a 16-bit feature word, a unit select bit and an optional cylinder/head/sector geometry. The block first selects the drive and polls status until the device is no longer busy. It then enables device interrupts, loads the parameter registers and writes the opcode as the final byte.

The addressing form is chosen per request. A request that fits in 28 bits goes out in the short form, either as a linear address or as cylinder/head/sector values derived from the geometry. A request that needs more address or count bits goes out in the extended form on a device that supports it. In that form each shared register takes two writes, the upper byte before the lower one, and the opcode is replaced by its extended counterpart. Data movement and DMA belong to other blocks.

Top module: `ata_cmd_issuer`

## Requirements
- R1: After reset `req_ready` is 1, `lba48_active` is 0 and no write or error is issued. `req_ready` is 1 only while the block is idle, and it returns to 1 in the cycle after the command write or the error pulse.
- R2: The first write of every request goes to the drive register (address 6) with the value 0xE0 | unit<<4. In every poll cycle whose status reads 0xFF, the block writes the drive register with 0xA0 | unit<<4 in that same cycle.
- R3: Polling stops at the first status byte that is not 0xFF and has bit 7 (busy) clear. If POLL_LIMIT polls all read busy or 0xFF, `cmd_err` pulses for one cycle, and neither the control register nor the command register is written.
- R4: Once busy clears, the control register (address 8) is written with 0x08, which leaves the interrupt-disable bit clear. This write comes before any parameter write.
- R5: The extended form is used exactly when (LBA >= 2^28 or count > 256) and `dev_lba48_ok` is 1. In every other case the short form is used.
- R6: Extended form, register addresses feature=1, count=2, sector=3, cyl-low=4, cyl-high=5. The writes are feature[15:8], feature[7:0], count[15:8], count[7:0], LBA[31:24], LBA[7:0] to sector, LBA[39:32], LBA[15:8] to cyl-low, LBA[47:40], LBA[23:16] to cyl-high, and then drive = 0x40 | unit<<4.
- R7: In the extended form the opcode is promoted: 0x20->0x24, 0xC4->0x29, 0xC8->0x25, 0xC7->0x26, 0x30->0x34, 0xC5->0x39, 0xCA->0x35, 0xCC->0x36, 0xE7->0xEA.
- R8: In the extended form, any opcode outside the R7 list gives a one-cycle `cmd_err` after the control write, and no parameter or command write follows. In the short form, every opcode is issued unchanged.
- R9: Short linear form, written in this order: feature[7:0], count[7:0], LBA[7:0], LBA[15:8], LBA[23:16], then drive = 0xE0 | unit<<4 | LBA[27:24].
- R10: Short geometry form (`req_use_chs`=1), written in this order: feature[7:0] and count[7:0] as in R9, then sector = (LBA mod S)+1, cyl-low and cyl-high = low and high bytes of LBA/(S*H), then drive = 0xA0 | unit<<4 | ((LBA mod (S*H))/S). Here S is the sectors per track and H the number of heads.
- R11: The opcode is written to the command register (address 7) as the last write of a successful request.
- R12: `lba48_active` updates when the command is written: it becomes 1 if the extended form was used and 0 otherwise. It holds its value across an error.
- R13: In the short form a count of 256 is written as 0x00. Only the low byte of the feature word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_opcode | input | 8 | Command opcode |
| req_lba | input | 48 | Block address |
| req_count | input | 16 | Sector count |
| req_feature | input | 16 | Feature word |
| req_unit | input | 1 | Unit select (0 or 1) |
| req_use_chs | input | 1 | Use geometry form for short commands |
| dev_lba48_ok | input | 1 | Device supports extended addressing |
| geo_heads | input | HEAD_W | Heads per cylinder |
| geo_sectors | input | SPT_W | Sectors per track |
| wr_en | output | 1 | Task-file write strobe |
| wr_addr | output | 4 | Task-file register address |
| wr_data | output | 8 | Byte written |
| st_rd | output | 1 | Status read strobe |
| st_data | input | 8 | Status byte, valid while st_rd is high |
| cmd_err | output | 1 | One-cycle error pulse |
| lba48_active | output | 1 | Last issued command used the extended form |

## Verification
In one poll cycle the block can read status and write the drive select at the same time. If that cycle is also the last one the poll budget allows, the timeout happens there as well. The bench holds status at 0xFF for set numbers of polls, covering 0xFF runs that end inside the budget, exactly at its edge and beyond it. For each run it compares the exact write log and the error pulse with a sequence built from R2 and R3, so a reselect dropped in the timeout cycle, or a spurious control write, shows as a mismatch.

// File: rtl/ata_issuer_pkg.sv
// Shared encodings for the task-file command issuer.
// Assumes register addresses follow the standard command-block offsets,
// with the device control register placed at address 8.
package ata_issuer_pkg;

    localparam logic [3:0] TF_FEAT  = 4'd1;
    localparam logic [3:0] TF_COUNT = 4'd2;
    localparam logic [3:0] TF_SECT  = 4'd3;
    localparam logic [3:0] TF_CYLLO = 4'd4;
    localparam logic [3:0] TF_CYLHI = 4'd5;
    localparam logic [3:0] TF_DRIVE = 4'd6;
    localparam logic [3:0] TF_CMD   = 4'd7;
    localparam logic [3:0] TF_CTRL  = 4'd8;

    localparam logic [7:0] DRV_SEL_LBA  = 8'hE0;  // select with LBA bit
    localparam logic [7:0] DRV_SEL_BARE = 8'hA0;  // select without LBA bit
    localparam logic [7:0] DRV_EXT      = 8'h40;  // extended-form drive byte
    localparam logic [7:0] CTRL_IRQ_ON  = 8'h08;  // interrupt-disable clear
    localparam logic [7:0] ST_FLOAT     = 8'hFF;  // no device driving bus

    typedef enum logic [2:0] {
        S_IDLE, S_SEL, S_POLL, S_CTRL, S_LOAD, S_CMD, S_ERR
    } issuer_state_e;

endpackage

// File: rtl/ata_op_promote.sv
// Maps a short-form opcode to its extended-addressing counterpart.
// Assumes: pure combinational lookup; 'known' low means no counterpart.
module ata_op_promote (
    input  logic [7:0] op_in,
    output logic [7:0] op_out,
    output logic       known
);
    // Lookup of the nine promotable opcodes.
    always_comb begin
        known  = 1'b1;
        op_out = op_in;
        case (op_in)
            8'h20: op_out = 8'h24;
            8'hC4: op_out = 8'h29;
            8'hC8: op_out = 8'h25;
            8'hC7: op_out = 8'h26;
            8'h30: op_out = 8'h34;
            8'hC5: op_out = 8'h39;
            8'hCA: op_out = 8'h35;
            8'hCC: op_out = 8'h36;
            8'hE7: op_out = 8'hEA;
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/ata_chs_geom.sv
// Converts a linear block address into cylinder, head and sector values.
// Assumes: heads and sectors non-zero for a meaningful result; a zero
// geometry yields all-zero outputs instead of a division by zero.
module ata_chs_geom #(
    parameter int LBA_W  = 28,
    parameter int HEAD_W = 5,
    parameter int SPT_W  = 8
) (
    input  logic [LBA_W-1:0]  lba,
    input  logic [HEAD_W-1:0] heads,
    input  logic [SPT_W-1:0]  spt,
    output logic [7:0]        sect,
    output logic [15:0]       cyl,
    output logic [3:0]        head
);
    localparam int TRK_W = HEAD_W + SPT_W;

    logic [TRK_W-1:0] trk;
    logic [LBA_W-1:0] spt_x, trk_x;

    // Widen geometry terms to address width for the divisions.
    always_comb begin
        trk   = TRK_W'(heads) * TRK_W'(spt);
        spt_x = LBA_W'(spt);
        trk_x = LBA_W'(trk);
    end

    // Geometry arithmetic with a zero-geometry guard.
    always_comb begin
        if (trk == '0) begin
            sect = 8'd0;
            cyl  = 16'd0;
            head = 4'd0;
        end else begin
            sect = 8'(lba % spt_x) + 8'd1;
            cyl  = 16'(lba / trk_x);
            head = 4'((lba % trk_x) / spt_x);
        end
    end
endmodule

// File: rtl/ata_cmd_issuer.sv
// Issues one ATA command through the task-file registers: select, wait
// for not-busy (with reselect on floating status), enable interrupts,
// load parameters in short or extended form, write the opcode last.
// Assumes: st_data is valid combinationally while st_rd is high; one
// write per cycle on the register port; synchronous active-low reset.
module ata_cmd_issuer
    import ata_issuer_pkg::*;
#(
    parameter int POLL_LIMIT = 1_000_000_000, // 5 s at 200 MHz
    parameter int HEAD_W     = 5,
    parameter int SPT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_opcode,
    input  logic [47:0]       req_lba,
    input  logic [15:0]       req_count,
    input  logic [15:0]       req_feature,
    input  logic              req_unit,
    input  logic              req_use_chs,
    input  logic              dev_lba48_ok,
    input  logic [HEAD_W-1:0] geo_heads,
    input  logic [SPT_W-1:0]  geo_sectors,
    output logic              wr_en,
    output logic [3:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              st_rd,
    input  logic [7:0]        st_data,
    output logic              cmd_err,
    output logic              lba48_active
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);
    localparam logic [47:0] LBA28_END = 48'h1000_0000;
    localparam logic [3:0]  LAST_EXT  = 4'd10;
    localparam logic [3:0]  LAST_SHORT = 4'd5;

    issuer_state_e state;
    logic [7:0]        r_op;
    logic [47:0]       r_lba;
    logic [15:0]       r_cnt, r_feat;
    logic              r_unit, r_chs, r_ext;
    logic [HEAD_W-1:0] r_heads;
    logic [SPT_W-1:0]  r_spt;
    logic [3:0]        step;
    logic [PC_W-1:0]   poll_cnt;

    logic [7:0]  ext_op;
    logic        ext_known;
    logic [7:0]  g_sect, g_head8;
    logic [15:0] g_cyl;
    logic [3:0]  g_head;
    logic [7:0]  unit_bit;
    logic        need_ext, dev_idle;
    logic [3:0]  ld_addr;
    logic [7:0]  ld_data;

    ata_op_promote u_promote (
        .op_in  (r_op),
        .op_out (ext_op),
        .known  (ext_known)
    );

    ata_chs_geom #(.LBA_W(28), .HEAD_W(HEAD_W), .SPT_W(SPT_W)) u_geom (
        .lba   (r_lba[27:0]),
        .heads (r_heads),
        .spt   (r_spt),
        .sect  (g_sect),
        .cyl   (g_cyl),
        .head  (g_head)
    );

    // Request-side decode: extended-form decision and status readiness.
    always_comb begin
        need_ext = ((req_lba >= LBA28_END) || (req_count > 16'd256)) && dev_lba48_ok;
        dev_idle = (st_data != ST_FLOAT) && !st_data[7];
        unit_bit = {3'b000, r_unit, 4'b0000};
        g_head8  = {4'b0000, g_head};
    end

    // Parameter write table indexed by load step.
    always_comb begin
        ld_addr = TF_FEAT;
        ld_data = 8'h00;
        if (r_ext) begin
            case (step)
                4'd0:  begin ld_addr = TF_FEAT;  ld_data = r_feat[15:8];  end
                4'd1:  begin ld_addr = TF_FEAT;  ld_data = r_feat[7:0];   end
                4'd2:  begin ld_addr = TF_COUNT; ld_data = r_cnt[15:8];   end
                4'd3:  begin ld_addr = TF_COUNT; ld_data = r_cnt[7:0];    end
                4'd4:  begin ld_addr = TF_SECT;  ld_data = r_lba[31:24];  end
                4'd5:  begin ld_addr = TF_SECT;  ld_data = r_lba[7:0];    end
                4'd6:  begin ld_addr = TF_CYLLO; ld_data = r_lba[39:32];  end
                4'd7:  begin ld_addr = TF_CYLLO; ld_data = r_lba[15:8];   end
                4'd8:  begin ld_addr = TF_CYLHI; ld_data = r_lba[47:40];  end
                4'd9:  begin ld_addr = TF_CYLHI; ld_data = r_lba[23:16];  end
                default: begin ld_addr = TF_DRIVE; ld_data = DRV_EXT | unit_bit; end
            endcase
        end else begin
            case (step)
                4'd0: begin ld_addr = TF_FEAT;  ld_data = r_feat[7:0]; end
                4'd1: begin ld_addr = TF_COUNT; ld_data = r_cnt[7:0];  end
                4'd2: begin ld_addr = TF_SECT;  ld_data = r_chs ? g_sect : r_lba[7:0]; end
                4'd3: begin ld_addr = TF_CYLLO; ld_data = r_chs ? g_cyl[7:0] : r_lba[15:8]; end
                4'd4: begin ld_addr = TF_CYLHI; ld_data = r_chs ? g_cyl[15:8] : r_lba[23:16]; end
                default: begin
                    ld_addr = TF_DRIVE;
                    ld_data = r_chs ? (DRV_SEL_BARE | unit_bit | g_head8)
                                    : (DRV_SEL_LBA | unit_bit | {4'b0000, r_lba[27:24]});
                end
            endcase
        end
    end

    // Port outputs decoded from the current state.
    always_comb begin
        req_ready = (state == S_IDLE);
        wr_en     = 1'b0;
        wr_addr   = 4'd0;
        wr_data   = 8'h00;
        st_rd     = 1'b0;
        cmd_err   = 1'b0;
        case (state)
            S_SEL:  begin wr_en = 1'b1; wr_addr = TF_DRIVE; wr_data = DRV_SEL_LBA | unit_bit; end
            S_POLL: begin
                st_rd = 1'b1;
                if (st_data == ST_FLOAT) begin
                    wr_en = 1'b1; wr_addr = TF_DRIVE; wr_data = DRV_SEL_BARE | unit_bit;
                end
            end
            S_CTRL: begin wr_en = 1'b1; wr_addr = TF_CTRL; wr_data = CTRL_IRQ_ON; end
            S_LOAD: begin wr_en = 1'b1; wr_addr = ld_addr; wr_data = ld_data; end
            S_CMD:  begin wr_en = 1'b1; wr_addr = TF_CMD;  wr_data = r_ext ? ext_op : r_op; end
            S_ERR:  cmd_err = 1'b1;
            default: ;
        endcase
    end

    // Sequencer: accept, select, poll, enable, load, issue or fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            step         <= 4'd0;
            poll_cnt     <= '0;
            lba48_active <= 1'b0;
            r_op <= 8'h00; r_lba <= '0; r_cnt <= '0; r_feat <= '0;
            r_unit <= 1'b0; r_chs <= 1'b0; r_ext <= 1'b0;
            r_heads <= '0; r_spt <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    r_op <= req_opcode; r_lba <= req_lba; r_cnt <= req_count;
                    r_feat <= req_feature; r_unit <= req_unit; r_chs <= req_use_chs;
                    r_ext <= need_ext; r_heads <= geo_heads; r_spt <= geo_sectors;
                    state <= S_SEL;
                end
                S_SEL: begin
                    poll_cnt <= '0;
                    state    <= S_POLL;
                end
                S_POLL: begin
                    if (dev_idle)
                        state <= S_CTRL;
                    else if (poll_cnt == PC_W'(POLL_LIMIT - 1))
                        state <= S_ERR;
                    else
                        poll_cnt <= poll_cnt + 1'b1;
                end
                S_CTRL: begin
                    step  <= 4'd0;
                    state <= (r_ext && !ext_known) ? S_ERR : S_LOAD;
                end
                S_LOAD: begin
                    if (step == (r_ext ? LAST_EXT : LAST_SHORT))
                        state <= S_CMD;
                    else
                        step <= step + 4'd1;
                end
                S_CMD: begin
                    lba48_active <= r_ext;
                    state        <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_CMD_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == TF_CMD) |=> req_ready); // R11
    AST_ERR_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> req_ready); // R1
    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!wr_en && !cmd_err && !st_rd)); // R1
    AST_FLOAT_RESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && st_data == ST_FLOAT) |-> (wr_en && wr_addr == TF_DRIVE)); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == TF_CMD) |=> $stable(lba48_active)); // R12
    AST_NO_CMD_WHILE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |-> !(wr_en && wr_addr != TF_DRIVE)); // R3
    AST_CTRL_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == TF_CTRL) |-> $past(st_rd)); // R4
endmodule

// File: tb/tb_ata_cmd_issuer.sv
module tb_ata_cmd_issuer;
    localparam int LIMIT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk; // 200 MHz

    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_opcode = 8'h00;
    logic [47:0] req_lba = '0;
    logic [15:0] req_count = '0, req_feature = '0;
    logic        req_unit = 1'b0, req_use_chs = 1'b0, dev_lba48_ok = 1'b0;
    logic [4:0]  geo_heads = 5'd1;
    logic [7:0]  geo_sectors = 8'd1;
    logic        wr_en, st_rd, cmd_err, lba48_active;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data, st_data;

    int ff_left = 0, busy_left = 0;
    assign st_data = (ff_left > 0) ? 8'hFF : (busy_left > 0) ? 8'h90 : 8'h50;

    ata_cmd_issuer #(.POLL_LIMIT(LIMIT), .HEAD_W(5), .SPT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_lba(req_lba), .req_count(req_count),
        .req_feature(req_feature), .req_unit(req_unit), .req_use_chs(req_use_chs),
        .dev_lba48_ok(dev_lba48_ok), .geo_heads(geo_heads), .geo_sectors(geo_sectors),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .st_rd(st_rd),
        .st_data(st_data), .cmd_err(cmd_err), .lba48_active(lba48_active)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    bit logging = 1'b0;
    int got_n = 0, exp_n = 0;
    bit got_err = 1'b0, exp_err = 1'b0, exp_flag = 1'b0;
    logic [3:0] got_a [0:63];
    logic [7:0] got_d [0:63];
    logic [3:0] exp_a [0:63];
    logic [7:0] exp_d [0:63];

    // Status model advances after the edge at which the poll was used.
    always @(posedge clk) begin
        if (st_rd) begin
            if (ff_left > 0) ff_left <= ff_left - 1;
            else if (busy_left > 0) busy_left <= busy_left - 1;
        end
    end

    // Write log, sampled mid-cycle.
    always @(negedge clk) begin
        if (logging) begin
            if (wr_en && got_n < 64) begin
                got_a[got_n] = wr_addr;
                got_d[got_n] = wr_data;
                got_n++;
            end
            if (cmd_err) got_err = 1'b1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int map_ext(input logic [7:0] op);
        case (op)
            8'h20: return 'h24; 8'hC4: return 'h29; 8'hC8: return 'h25;
            8'hC7: return 'h26; 8'h30: return 'h34; 8'hC5: return 'h39;
            8'hCA: return 'h35; 8'hCC: return 'h36; 8'hE7: return 'hEA;
            default: return -1;
        endcase
    endfunction

    task automatic push(input int a, input int d);
        exp_a[exp_n] = 4'(a);
        exp_d[exp_n] = 8'(d);
        exp_n++;
    endtask

    // Expected write sequence from the requirements.
    task automatic build(input logic [7:0] op, input logic [47:0] lba, input logic [15:0] cnt,
                         input logic [15:0] feat, input bit u, input bit chs, input bit ok48,
                         input int heads, input int spt, input int nff, input int nbusy);
        bit ext;
        int ub;
        bit idle_seen;
        exp_n = 0;
        exp_err = 1'b0;
        ub = u ? 'h10 : 0;
        ext = ((lba >= 48'h1000_0000) || (cnt > 16'd256)) && ok48;   // R5
        push(6, 'hE0 | ub);                                          // R2
        idle_seen = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin                        // R3
            if (i < nff) push(6, 'hA0 | ub);
            else if (i >= nff + nbusy) begin idle_seen = 1'b1; break; end
        end
        if (!idle_seen) begin exp_err = 1'b1; return; end
        push(8, 'h08);                                               // R4
        if (ext && map_ext(op) < 0) begin exp_err = 1'b1; return; end // R8
        if (ext) begin                                               // R6
            push(1, feat[15:8]); push(1, feat[7:0]);
            push(2, cnt[15:8]);  push(2, cnt[7:0]);
            push(3, lba[31:24]); push(3, lba[7:0]);
            push(4, lba[39:32]); push(4, lba[15:8]);
            push(5, lba[47:40]); push(5, lba[23:16]);
            push(6, 'h40 | ub);
            push(7, map_ext(op));                                    // R7
        end else begin
            push(1, feat[7:0]); push(2, cnt[7:0]);                   // R13
            if (chs) begin                                           // R10
                int l, trk;
                l = int'(lba[27:0]);
                trk = heads * spt;
                push(3, (l % spt) + 1);
                push(4, (l / trk) & 'hFF);
                push(5, ((l / trk) >> 8) & 'hFF);
                push(6, 'hA0 | ub | (((l % trk) / spt) & 'hF));
            end else begin                                           // R9
                push(3, lba[7:0]); push(4, lba[15:8]); push(5, lba[23:16]);
                push(6, 'hE0 | ub | lba[27:24]);
            end
            push(7, op);                                             // R11
        end
        exp_flag = ext;                                              // R12
    endtask

    task automatic run(input logic [7:0] op, input logic [47:0] lba, input logic [15:0] cnt,
                       input logic [15:0] feat, input bit u, input bit chs, input bit ok48,
                       input int heads, input int spt, input int nff, input int nbusy,
                       input string tag);
        bit mism;
        build(op, lba, cnt, feat, u, chs, ok48, heads, spt, nff, nbusy);
        @(negedge clk);
        req_opcode = op; req_lba = lba; req_count = cnt; req_feature = feat;
        req_unit = u; req_use_chs = chs; dev_lba48_ok = ok48;
        geo_heads = 5'(heads); geo_sectors = 8'(spt);
        ff_left = nff; busy_left = nbusy;
        got_n = 0; got_err = 1'b0; logging = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && !req_ready; k++) @(negedge clk);
        logging = 1'b0;
        mism = (got_n != exp_n);
        for (int k = 0; k < exp_n && !mism; k++)
            if (got_a[k] !== exp_a[k] || got_d[k] !== exp_d[k]) begin
                mism = 1'b1;
                $display("FAIL %s write %0d actual=%0h:%0h expected=%0h:%0h",
                         tag, k, got_a[k], got_d[k], exp_a[k], exp_d[k]);
            end
        check(!mism, {tag, " write sequence length"}, got_n, exp_n);
        check(got_err == exp_err, {tag, " error pulse"}, int'(got_err), int'(exp_err));
        check(lba48_active == exp_flag, {tag, " R12 extended flag"}, int'(lba48_active), int'(exp_flag));
    endtask

    initial begin
        automatic logic [7:0]  ops28 [3] = '{8'h20, 8'hC8, 8'hEC};
        automatic logic [47:0] lbas28 [3] = '{48'h0, 48'h0FFF_FFFF, 48'h0ABC_DEF1};
        automatic logic [15:0] cnts28 [3] = '{16'd1, 16'd255, 16'd256};
        automatic logic [7:0]  opsx [10] = '{8'h20, 8'hC4, 8'hC8, 8'hC7, 8'h30,
                                             8'hC5, 8'hCA, 8'hCC, 8'hE7, 8'hEC};
        automatic int hs [3] = '{1, 4, 16};
        automatic int ss [3] = '{1, 17, 63};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(lba48_active == 1'b0, "R1 flag after reset", int'(lba48_active), 0);
        check(!wr_en && !cmd_err, "R1 quiet after reset", int'(wr_en), 0);

        // R9 R13: short linear form, bounds of the 28-bit range
        foreach (ops28[i]) foreach (lbas28[j]) foreach (cnts28[k])
            run(ops28[i], lbas28[j], cnts28[k], 16'hA55A, (j % 2) == 1, 1'b0, 1'b1,
                1, 1, 0, 1, "R9/R13 short linear");

        // R5 R6 R7 R8 R12: extended trigger by address and by count, with and without support
        foreach (opsx[i]) begin
            run(opsx[i], 48'hFEDC_1000_0000, 16'h0003, 16'h1234, 1'b1, 1'b0, 1'b1,
                1, 1, 0, 0, "R6/R7/R8 extended by address");
            run(opsx[i], 48'h0000_0000_1000, 16'd257, 16'hBEEF, 1'b0, 1'b0, 1'b1,
                1, 1, 0, 2, "R5 extended by count");
            run(opsx[i], 48'h0ABC_1000_0000, 16'd257, 16'h00FF, 1'b0, 1'b0, 1'b0,
                1, 1, 0, 0, "R5 no device support");
        end

        // R10: geometry form
        foreach (hs[i]) foreach (ss[j]) begin
            run(8'h20, 48'd0, 16'd8, 16'h0, 1'b0, 1'b1, 1'b1, hs[i], ss[j], 0, 0, "R10 geometry zero");
            run(8'h30, 48'd123456, 16'd8, 16'h0, 1'b1, 1'b1, 1'b1, hs[i], ss[j], 0, 0, "R10 geometry mid");
            run(8'hC8, 48'd1007, 16'd8, 16'h0, 1'b0, 1'b1, 1'b1, hs[i], ss[j], 0, 1, "R10 geometry small");
        end

        // R2 R3 R4: floating and busy status around the poll budget
        for (int f = 0; f <= 4; f++)
            for (int b = 0; b <= LIMIT - f + 1; b++)
                run(8'h20, 48'h1234, 16'd4, 16'h0, (b % 2) == 0, 1'b0, 1'b0,
                    1, 1, f, b, "R2/R3/R4 poll budget");
        run(8'h20, 48'h1234, 16'd4, 16'h0, 1'b1, 1'b0, 1'b0, 1, 1, LIMIT + 2, 0,
            "R2/R3 float through timeout");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule